// File: doc/BRIEF.md
# Passive LCD Scan Timing Generator

This block produces the raw timing strobes that drive a passive-matrix monochrome or grey-scale LCD panel from a 36.864 MHz reference clock. Its outputs are a gated pixel shift clock, a line-latch pulse, a frame-start marker and an AC-drive polarity signal. It also provides a live count of the current line. Framebuffer fetch and pixel formatting sit in neighbouring blocks. Those blocks follow the shift clock and the line pulse to place data on the panel bus.

Each line is built from shift-clock slots. The first `horz_xfers + 1` slots each carry one shift-clock pulse, one per bus transfer. The final slot carries no shift clock and holds the line pulse high. Software sets `horz_xfers` from the transfer count for the chosen bus: 4-bit transfers for 4-bit or split panels, and 8-bit transfers for an 8-bit non-split panel. For a split panel, `frame_lines` gives the lines per half. Divisor and mode inputs go into shadow registers. Those registers reload only at a frame boundary, or continuously while video is disabled, so a mid-frame write never breaks a frame.

Top module: `lcd_scan_timer`

## Requirements
- R1: `shift_clk` has a period of exactly 2·(`shift_div`+1) reference cycles, low for the first half of each period and high for the second.
- R2: A line consists of `horz_xfers`+1 shift-clock periods with a pulse, followed by one shift-clock period in which `shift_clk` stays low and `line_pulse` is high.
- R3: A frame contains `frame_lines`+1 lines. `cur_line` counts 0 up to `frame_lines`, and `frame_pulse` is high during the whole of line 0.
- R4: `ac_drive` starts low and inverts once every `ac_div`+1 completed lines. The count runs on across frame boundaries.
- R5: While `vid_en` is low, every counter is held at zero. `shift_clk`, `line_pulse`, `frame_pulse`, `ac_drive` and `cur_line` read zero from the first edge that samples `vid_en` low, and `panel_mode` reads zero too.
- R6: `disp_on` and `invert_out` equal `vid_en` AND their own control input, as sampled on the previous clock edge.
- R7: A change to `shift_div`, `horz_xfers`, `frame_lines`, `ac_div`, `split_sel` or `wide_sel` made while the scan runs takes effect at the first edge after the last slot of the current frame. While the scan is disabled, the inputs are taken up directly.
- R8: While the scan runs, `panel_mode` shows the latched panel mode: bit 1 is split-panel and bit 0 is 8-bit bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 36.864 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_en | input | 1 | Runs the scan when high; holds everything in reset when low |
| disp_cfg | input | 1 | Requested display-on level |
| invert_cfg | input | 1 | Requested video invert level |
| split_sel | input | 1 | Split (dual-scan) panel select |
| wide_sel | input | 1 | 8-bit bus select |
| shift_div | input | 5 | Shift-clock divisor N, rate = ref/(2N+2) |
| horz_xfers | input | 9 | Transfers per line minus one |
| frame_lines | input | 10 | Lines per frame (or per half) minus one |
| ac_div | input | 8 | AC-drive divisor, in lines minus one |
| shift_clk | output | 1 | Pixel shift clock |
| line_pulse | output | 1 | Line latch pulse |
| frame_pulse | output | 1 | High during the first line of a frame |
| ac_drive | output | 1 | AC-drive polarity |
| cur_line | output | 10 | Current line number |
| disp_on | output | 1 | Display-on output |
| invert_out | output | 1 | Video invert output |
| panel_mode | output | 2 | Latched {split, 8-bit} mode |

## Verification
The bench checks every port against the reference model on every clock. A prescaler that is off by one shows within the first shift-clock period as a `shift_clk` edge one cycle early or late. A wrong slot counter shows at the end of the first line, when `line_pulse` appears or disappears in the wrong cycle. Faults in the line or AC-drive counters show within one frame as a wrong `cur_line` value or a misplaced `ac_drive` edge. A shadow register that reloads too early shows the new timing inside a frame that should still use the old settings.

// File: rtl/lcd_scan_pkg.sv
// Shared field widths and the shadow configuration record for the
// passive LCD scan timer. Assumes fields are plain binary counts.
package lcd_scan_pkg;
    parameter int DIV_W  = 5;
    parameter int HORZ_W = 9;
    parameter int LINE_W = 10;
    parameter int AC_W   = 8;

    typedef struct packed {
        logic              split;
        logic              wide;
        logic [DIV_W-1:0]  div;
        logic [HORZ_W-1:0] horz;
        logic [LINE_W-1:0] lines;
        logic [AC_W-1:0]   ac;
    } scan_cfg_t;
endpackage

// File: rtl/lcd_clk_div.sv
// Shift-clock prescaler: toggles a phase bit every (div+1) cycles, so the
// phase has period 2*(div+1). Assumes div is stable while run is high,
// except at the period end where the owner may reload it.
module lcd_clk_div #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             phase,
    output logic             period_end
);
    logic [DIV_W-1:0] pre_q;
    logic             tick;

    // Half-period terminal count.
    assign tick       = (pre_q == div);
    assign period_end = run && tick && phase;
    // Advance the prescaler and toggle the phase at each half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
            phase <= 1'b0;
        end else if (tick) begin
            pre_q <= '0;
            phase <= ~phase;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    p_pre_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre_q <= div));
    p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(phase) || !run);
endmodule

// File: rtl/lcd_line_scan.sv
// Slot and line counters. A line has horz+2 slots; the last slot is the
// line-pulse slot. Emits line_end and frame_end on the final cycle of the
// last slot. Assumes slot_end pulses once per shift-clock period.
module lcd_line_scan #(
    parameter int HORZ_W = 9,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              slot_end,
    input  logic [HORZ_W-1:0] horz,
    input  logic [LINE_W-1:0] lines,
    output logic              lp_slot,
    output logic              line_end,
    output logic              frame_end,
    output logic [LINE_W-1:0] line_q
);
    localparam int SLOT_W = HORZ_W + 1;

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] last_slot;

    assign last_slot = {1'b0, horz} + SLOT_W'(1);
    assign lp_slot   = (slot_q == last_slot);
    assign line_end  = slot_end && lp_slot;
    assign frame_end = line_end && (line_q == lines);

    // Step the slot counter once per shift-clock period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   slot_q <= '0;
        else if (line_end)    slot_q <= '0;
        else if (slot_end)    slot_q <= slot_q + 1'b1;
    end

    // Step the line counter at each line end, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   line_q <= '0;
        else if (frame_end)   line_q <= '0;
        else if (line_end)    line_q <= line_q + 1'b1;
    end

    p_line_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (line_q <= lines));
    p_slot_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (slot_q <= last_slot));
endmodule

// File: rtl/lcd_ac_gen.sv
// AC-drive generator: counts completed lines and inverts its output every
// (div+1) lines. Assumes line_end is a single-cycle pulse.
module lcd_ac_gen #(
    parameter int AC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            line_end,
    input  logic [AC_W-1:0] div,
    output logic            ac_q
);
    logic [AC_W-1:0] cnt_q;

    // Count lines and toggle polarity on the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            ac_q  <= 1'b0;
        end else if (line_end) begin
            if (cnt_q == div) begin
                cnt_q <= '0;
                ac_q  <= ~ac_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_ac_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !line_end) |=> $stable(ac_q));
endmodule

// File: rtl/lcd_scan_timer.sv
// Top of the passive LCD scan timer. Holds the shadow configuration,
// the run flag and the output gating. Assumes a single clock domain at
// the reference frequency and synchronous active-low reset.
module lcd_scan_timer
    import lcd_scan_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int HW = HORZ_W,
    parameter int LW = LINE_W,
    parameter int AW = AC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vid_en,
    input  logic          disp_cfg,
    input  logic          invert_cfg,
    input  logic          split_sel,
    input  logic          wide_sel,
    input  logic [DW-1:0] shift_div,
    input  logic [HW-1:0] horz_xfers,
    input  logic [LW-1:0] frame_lines,
    input  logic [AW-1:0] ac_div,
    output logic          shift_clk,
    output logic          line_pulse,
    output logic          frame_pulse,
    output logic          ac_drive,
    output logic [LW-1:0] cur_line,
    output logic          disp_on,
    output logic          invert_out,
    output logic [1:0]    panel_mode
);
    logic          run_q;
    logic          phase;
    logic          slot_end;
    logic          lp_slot;
    logic          line_end;
    logic          frame_end;
    logic          ac_q;
    logic [LW-1:0] line_q;
    logic          split_s, wide_s;
    logic [DW-1:0] div_s;
    logic [HW-1:0] horz_s;
    logic [LW-1:0] lines_s;
    logic [AW-1:0] ac_s;

    // Run flag: one register stage behind vid_en.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= vid_en;
    end

    // Shadow configuration: follows inputs while idle, reloads at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_s <= 1'b0;
            wide_s  <= 1'b0;
            div_s   <= '0;
            horz_s  <= '0;
            lines_s <= '0;
            ac_s    <= '0;
        end else if (!run_q || frame_end) begin
            split_s <= split_sel;
            wide_s  <= wide_sel;
            div_s   <= shift_div;
            horz_s  <= horz_xfers;
            lines_s <= frame_lines;
            ac_s    <= ac_div;
        end
    end

    // Display-on and invert outputs, qualified by the video enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_on    <= 1'b0;
            invert_out <= 1'b0;
        end else begin
            disp_on    <= vid_en && disp_cfg;
            invert_out <= vid_en && invert_cfg;
        end
    end

    lcd_clk_div #(.DIV_W(DW)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .div        (div_s),
        .phase      (phase),
        .period_end (slot_end)
    );

    lcd_line_scan #(.HORZ_W(HW), .LINE_W(LW)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .slot_end  (slot_end),
        .horz      (horz_s),
        .lines     (lines_s),
        .lp_slot   (lp_slot),
        .line_end  (line_end),
        .frame_end (frame_end),
        .line_q    (line_q)
    );

    lcd_ac_gen #(.AC_W(AW)) u_ac (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .line_end (line_end),
        .div      (ac_s),
        .ac_q     (ac_q)
    );

    assign shift_clk   = run_q && phase && !lp_slot;
    assign line_pulse  = run_q && lp_slot;
    assign frame_pulse = run_q && (line_q == '0);
    assign ac_drive    = run_q && ac_q;
    assign cur_line    = run_q ? line_q : '0;
    assign panel_mode  = run_q ? {split_s, wide_s} : 2'b00;

    p_lp_no_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse |-> !shift_clk);
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_en |=> (!shift_clk && !line_pulse && !frame_pulse && !ac_drive && cur_line == '0));
    p_disp_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_on |-> $past(vid_en && disp_cfg));
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && vid_en && !frame_end) |=> $stable(horz_s) && $stable(lines_s) && $stable(div_s));
endmodule

// File: tb/lcd_scan_timer_tb.sv
module lcd_scan_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vid_en = 1'b0, disp_cfg = 1'b0, invert_cfg = 1'b0;
    logic       split_sel = 1'b0, wide_sel = 1'b0;
    logic [4:0] shift_div = '0;
    logic [8:0] horz_xfers = '0;
    logic [9:0] frame_lines = '0;
    logic [7:0] ac_div = '0;
    logic       shift_clk, line_pulse, frame_pulse, ac_drive, disp_on, invert_out;
    logic [9:0] cur_line;
    logic [1:0] panel_mode;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;
    string phase_tag = "R3";

    // reference model state
    bit m_run = 0, m_ac = 0, m_disp = 0, m_inv = 0, m_split = 0, m_wide = 0;
    int m_sub = 0, m_slot = 0, m_line = 0, m_acn = 0;
    int c_div = 0, c_horz = 0, c_lines = 0, c_ac = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_scan_timer u_dut (
        .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .disp_cfg(disp_cfg),
        .invert_cfg(invert_cfg), .split_sel(split_sel), .wide_sel(wide_sel),
        .shift_div(shift_div), .horz_xfers(horz_xfers), .frame_lines(frame_lines),
        .ac_div(ac_div), .shift_clk(shift_clk), .line_pulse(line_pulse),
        .frame_pulse(frame_pulse), .ac_drive(ac_drive), .cur_line(cur_line),
        .disp_on(disp_on), .invert_out(invert_out), .panel_mode(panel_mode));

    task automatic take_cfg();
        c_div = shift_div; c_horz = horz_xfers; c_lines = frame_lines;
        c_ac = ac_div; m_split = split_sel; m_wide = wide_sel;
    endtask

    // Behavioural model: time within slot, slot within line, lines, AC count.
    always @(posedge clk) begin
        m_disp = rst_n && vid_en && disp_cfg;
        m_inv  = rst_n && vid_en && invert_cfg;
        if (!rst_n || !vid_en) begin
            m_run = 0; m_sub = 0; m_slot = 0; m_line = 0; m_acn = 0; m_ac = 0;
            take_cfg();
        end else if (!m_run) begin
            m_run = 1;
            take_cfg();
        end else begin
            m_sub++;
            if (m_sub == 2 * (c_div + 1)) begin
                m_sub = 0;
                m_slot++;
                if (m_slot == c_horz + 2) begin
                    m_slot = 0;
                    m_acn++;
                    if (m_acn == c_ac + 1) begin m_acn = 0; m_ac = ~m_ac; end
                    if (m_line == c_lines) begin m_line = 0; take_cfg(); end
                    else m_line++;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Compare every port with the model away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            if (!m_run) begin
                chk("R5", "idle strobes", {shift_clk, line_pulse, frame_pulse, ac_drive}, 0);
                chk("R5", "idle line", cur_line, 0);
                chk("R5", "idle mode", panel_mode, 0);
            end else begin
                chk("R1", "shift_clk", shift_clk,
                    (m_sub >= c_div + 1) && (m_slot <= c_horz));
                chk("R2", "line_pulse", line_pulse, m_slot == c_horz + 1);
                chk(phase_tag, "frame_pulse", frame_pulse, m_line == 0);
                chk(phase_tag, "cur_line", cur_line, m_line);
                chk("R4", "ac_drive", ac_drive, m_ac);
                chk("R8", "panel_mode", panel_mode, {m_split, m_wide});
            end
            chk("R6", "disp_on", disp_on, m_disp);
            chk("R6", "invert_out", invert_out, m_inv);
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic setcfg(input int d, input int h, input int l, input int a);
        shift_div = 5'(d); horz_xfers = 9'(h); frame_lines = 10'(l); ac_div = 8'(a);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        // reset state (R5, R6)
        chk("R5", "reset strobes", {shift_clk, line_pulse, frame_pulse, ac_drive}, 0);
        chk("R6", "reset disp_on", disp_on, 0);
        rst_n = 1'b1;
        setcfg(1, 3, 2, 1);
        disp_cfg = 1'b1;
        wait_n(5);
        vid_en = 1'b1;                  // R1 R2 R3 R4 basic scan
        wait_n(250);
        setcfg(0, 1, 4, 2);             // R7 mid-frame change
        phase_tag = "R7";
        wait_n(30);
        phase_tag = "R3";
        wait_n(300);
        setcfg(3, 0, 0, 0);             // boundary: one transfer, one line
        invert_cfg = 1'b1;
        wait_n(300);
        vid_en = 1'b0;                  // R5 disable window
        wait_n(12);
        split_sel = 1'b1; wide_sel = 1'b1;
        setcfg(2, 5, 1, 3);
        vid_en = 1'b1;                  // R8 mode latched
        wait_n(500);
        vid_en = 1'b0;                  // single-cycle drop
        @(negedge clk);
        vid_en = 1'b1;
        disp_cfg = 1'b0;
        setcfg(31, 2, 1, 0);            // largest divisor
        wait_n(40);
        wide_sel = 1'b0;                // R7: mode change waits for frame end
        wait_n(1300);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule